// File: doc/BRIEF.md
# Single-Precision to Unsigned 64-bit Integer Converter

This block turns one IEEE-754 single-precision operand into a 64-bit unsigned integer. It splits the operand into sign, biased exponent and fraction, restores the hidden bit for normal values, and aligns the significand into a fixed-point window of 64 integer bits plus a guard bit and a sticky bit. The rounding mode is supplied with each operand. Under that mode the aligned value is rounded to an integer. The block then reports whether the result was exact and whether it can be represented.

The invalid exception is always treated as masked. Any operand that cannot be represented gives the all-ones pattern with the invalid flag set. NaN of either kind, both infinities, values of 2^64 or more after rounding, and negative values that round to -1 or lower are all unrepresentable. A negative operand that rounds to zero is legal and gives 0.

The inputs are captured on every rising clock edge. All three results are registered, so a result belongs to the operand presented one cycle earlier.

Internally the operand is first classified into one of five named classes: ZERO, SUBNORMAL, NORMAL, INFINITY and NAN. Each class has its own alignment path, selected by a unique case. The block has no other sequencing. After reset it is always in its single operating condition, accepting one operand per cycle, and there are no state transitions.

Top module: `f2u_conv`

## Requirements
- R1: An operand that is already a non-negative integer below 2^64 is returned exactly, with both flags low, in every rounding mode.
- R2: With mode select 2'b00 (round to nearest), a value is rounded to the nearest integer, and an exact tie goes to the even integer (0.5 gives 0, 1.5 gives 2, 2.5 gives 2, 3.5 gives 4).
- R3: With mode select 2'b01 (toward minus infinity), the value is rounded down. Any negative operand with a nonzero fractional part therefore rounds to -1 or lower and is invalid.
- R4: With mode select 2'b10 (toward plus infinity), the value is rounded up. A negative operand above -1 gives 0 with inexact set.
- R5: With mode select 2'b11 (toward zero), the fractional part is discarded.
- R6: NaN (quiet or signalling) and both infinities give result 64'hFFFF_FFFF_FFFF_FFFF with invalid high and inexact low.
- R7: Any operand whose rounded value is 2^64 or more is invalid and gives all ones. Every biased exponent of 191 or higher is out of range. The largest finite in-range operand, 32'h5F7F_FFFF, gives 64'hFFFF_FF00_0000_0000.
- R8: A negative operand that rounds to zero gives 0 and is valid. Negative zero gives 0 with no flags. A negative operand that rounds to -1 or below (for example -1.0) is invalid.
- R9: A subnormal operand gives 0 or 1 as the mode dictates (1 only for positive operands rounded up) and sets inexact unless it is invalid.
- R10: Inexact is high exactly when the operand is not an integer and the result is valid. Inexact is never high together with invalid.
- R11: The result and both flags are registered. They reflect the operand and mode sampled at the previous rising edge. An active-low asynchronous reset clears all three outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; operands are captured on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_i | input | 32 | Single-precision operand |
| rm_i | input | 2 | Rounding mode: 00 nearest-even, 01 down, 10 up, 11 toward zero |
| result_o | output | 64 | Unsigned integer result, or all ones when invalid |
| invalid_o | output | 1 | Operand not representable |
| inexact_o | output | 1 | Result differs from operand value |

## Verification
Every result and both flags are due exactly one rising edge after the operand and mode are applied. There are no longer paths.

The bench drives a new operand on each falling edge and pushes the expected triple into a queue. On the next falling edge it pops and compares that triple, so each comparison falls half a period after the edge that loaded the register. This also compares the design on every clock without gaps.

While reset is held, the outputs are checked to stay at zero even with a live operand applied.

// File: rtl/f2u_pkg.sv
package f2u_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_DOWN    = 2'b01,
        RM_UP      = 2'b10,
        RM_ZERO    = 2'b11
    } rmode_e;

    typedef enum logic [2:0] {
        CL_ZERO      = 3'd0,
        CL_SUBNORMAL = 3'd1,
        CL_NORMAL    = 3'd2,
        CL_INFINITY  = 3'd3,
        CL_NAN       = 3'd4
    } fclass_e;

endpackage

// File: rtl/f2u_classify.sv
module f2u_classify
    import f2u_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] fp_i,
    output logic                 sign_o,
    output logic [EXP_W-1:0]     exp_o,
    output logic [MAN_W-1:0]     man_o,
    output fclass_e              cls_o
);
    localparam int FP_W = EXP_W + MAN_W + 1;

    logic exp_all_ones;
    logic exp_all_zero;
    logic man_zero;

    assign sign_o = fp_i[FP_W-1];
    assign exp_o  = fp_i[FP_W-2 -: EXP_W];
    assign man_o  = fp_i[MAN_W-1:0];

    assign exp_all_ones = &exp_o;
    assign exp_all_zero = ~|exp_o;
    assign man_zero     = ~|man_o;

    always_comb begin
        if (exp_all_ones) begin
            cls_o = man_zero ? CL_INFINITY : CL_NAN;
        end else if (exp_all_zero) begin
            cls_o = man_zero ? CL_ZERO : CL_SUBNORMAL;
        end else begin
            cls_o = CL_NORMAL;
        end
    end

endmodule

// File: rtl/f2u_align.sv
module f2u_align
    import f2u_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 64
) (
    input  fclass_e          cls_i,
    input  logic [EXP_W-1:0] exp_i,
    input  logic [MAN_W-1:0] man_i,
    output logic [INT_W-1:0] int_o,
    output logic             guard_o,
    output logic             sticky_o,
    output logic             big_o
);
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int SIG_W = MAN_W + 1;
    localparam int EXT_W = INT_W + MAN_W;

    logic [SIG_W-1:0] sig;
    logic [EXT_W-1:0] ext;
    int               unb_exp;

    assign sig = {1'b1, man_i};

    always_comb begin
        unb_exp  = int'(exp_i) - BIAS;
        ext      = '0;
        int_o    = '0;
        guard_o  = 1'b0;
        sticky_o = 1'b0;
        big_o    = 1'b0;
        unique case (cls_i)
            CL_ZERO: begin
                sticky_o = 1'b0;
            end
            CL_SUBNORMAL: begin
                sticky_o = 1'b1;
            end
            CL_NORMAL: begin
                if (unb_exp >= INT_W) begin
                    big_o = 1'b1;
                end else if (unb_exp >= 0) begin
                    ext      = EXT_W'(sig) << unb_exp;
                    int_o    = ext[EXT_W-1 -: INT_W];
                    guard_o  = ext[MAN_W-1];
                    sticky_o = |ext[MAN_W-2:0];
                end else if (unb_exp == -1) begin
                    guard_o  = 1'b1;
                    sticky_o = |man_i;
                end else begin
                    sticky_o = 1'b1;
                end
            end
            CL_INFINITY, CL_NAN: begin
                big_o = 1'b0;
            end
            default: begin
                big_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/f2u_round.sv
module f2u_round
    import f2u_pkg::*;
#(
    parameter int INT_W = 64
) (
    input  rmode_e           rm_i,
    input  fclass_e          cls_i,
    input  logic             sign_i,
    input  logic             big_i,
    input  logic [INT_W-1:0] int_i,
    input  logic             guard_i,
    input  logic             sticky_i,
    output logic [INT_W-1:0] result_o,
    output logic             invalid_o,
    output logic             inexact_o
);
    logic             frac_nz;
    logic             inc;
    logic             carry;
    logic [INT_W-1:0] mag;
    logic             special;

    assign frac_nz = guard_i | sticky_i;
    assign special = (cls_i == CL_NAN) || (cls_i == CL_INFINITY);

    always_comb begin
        unique case (rm_i)
            RM_NEAREST: inc = guard_i & (sticky_i | int_i[0]);
            RM_DOWN:    inc = sign_i & frac_nz;
            RM_UP:      inc = ~sign_i & frac_nz;
            RM_ZERO:    inc = 1'b0;
            default:    inc = 1'b0;
        endcase
    end

    always_comb begin
        {carry, mag} = {1'b0, int_i} + {{INT_W{1'b0}}, inc};
        invalid_o    = special | big_i | carry | (sign_i & (|mag));
        inexact_o    = ~invalid_o & frac_nz;
        if (invalid_o) begin
            result_o = '1;
        end else if (sign_i) begin
            result_o = '0;
        end else begin
            result_o = mag;
        end
    end

endmodule

// File: rtl/f2u_conv.sv
module f2u_conv
    import f2u_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [EXP_W+MAN_W:0]     fp_i,
    input  logic [1:0]               rm_i,
    output logic [INT_W-1:0]         result_o,
    output logic                     invalid_o,
    output logic                     inexact_o
);
    logic             sign;
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    fclass_e          cls;
    logic [INT_W-1:0] int_part;
    logic             guard;
    logic             sticky;
    logic             big;
    rmode_e           rm;
    logic [INT_W-1:0] result_d;
    logic             invalid_d;
    logic             inexact_d;

    assign rm = rmode_e'(rm_i);

    f2u_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_class (
        .fp_i   (fp_i),
        .sign_o (sign),
        .exp_o  (exp_f),
        .man_o  (man_f),
        .cls_o  (cls)
    );

    f2u_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_align (
        .cls_i    (cls),
        .exp_i    (exp_f),
        .man_i    (man_f),
        .int_o    (int_part),
        .guard_o  (guard),
        .sticky_o (sticky),
        .big_o    (big)
    );

    f2u_round #(.INT_W(INT_W)) u_round (
        .rm_i      (rm),
        .cls_i     (cls),
        .sign_i    (sign),
        .big_i     (big),
        .int_i     (int_part),
        .guard_i   (guard),
        .sticky_i  (sticky),
        .result_o  (result_d),
        .invalid_o (invalid_d),
        .inexact_o (inexact_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o  <= '0;
            invalid_o <= 1'b0;
            inexact_o <= 1'b0;
        end else begin
            result_o  <= result_d;
            invalid_o <= invalid_d;
            inexact_o <= inexact_d;
        end
    end

endmodule

// File: rtl/f2u_conv_chk.sv
module f2u_conv_chk #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [EXP_W+MAN_W:0] fp_i,
    input logic [1:0]           rm_i,
    input logic [INT_W-1:0]     result_o,
    input logic                 invalid_o,
    input logic                 inexact_o
);
    localparam int FP_W = EXP_W + MAN_W + 1;
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    logic             sg;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] mn;

    assign sg = fp_i[FP_W-1];
    assign ex = fp_i[FP_W-2 -: EXP_W];
    assign mn = fp_i[MAN_W-1:0];

    assert_special_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (&ex) |=> (invalid_o && !inexact_o && (&result_o)));

    assert_range_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&ex) && (int'(ex) >= BIAS + INT_W)) |=> invalid_o);

    assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> (&result_o));

    assert_flag_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> !inexact_o);

    assert_zero_exact_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ex == '0) && (mn == '0)) |=> (result_o == '0 && !invalid_o && !inexact_o));

    assert_subnormal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((ex == '0) && (mn != '0)) |=> (invalid_o || (inexact_o && result_o <= 1)));

    assert_trunc_negative_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sg && rm_i == 2'b11 && int'(ex) < BIAS) |=> (result_o == '0 && !invalid_o));

endmodule

bind f2u_conv f2u_conv_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fp_i      (fp_i),
    .rm_i      (rm_i),
    .result_o  (result_o),
    .invalid_o (invalid_o),
    .inexact_o (inexact_o)
);

// File: tb/sim_f2u_conv.sv
`timescale 1ns/1ps
module sim_f2u_conv;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fp_i = 32'h0;
    logic [1:0]  rm_i = 2'b00;
    logic [63:0] result_o;
    logic        invalid_o;
    logic        inexact_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0] q_res[$];
    logic        q_inv[$];
    logic        q_inx[$];
    string       q_req[$];

    always #10 clk = ~clk;

    f2u_conv u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .fp_i      (fp_i),
        .rm_i      (rm_i),
        .result_o  (result_o),
        .invalid_o (invalid_o),
        .inexact_o (inexact_o)
    );

    task automatic ref_conv(input logic [31:0] f, input logic [1:0] m,
                            output logic [63:0] r, output logic inv, output logic inx);
        logic         s;
        int           e;
        logic [23:0]  sig;
        logic [127:0] q;
        logic         lost;
        logic [63:0]  ip;
        logic         half, rest, exact, up;
        logic [64:0]  mag;
        s   = f[31];
        e   = int'(f[30:23]);
        r   = '1;
        inv = 1'b1;
        inx = 1'b0;
        if (e == 255 || e >= 191) return;
        if (e == 0) begin
            sig = {1'b0, f[22:0]};
            e   = 1;
        end else begin
            sig = {1'b1, f[22:0]};
        end
        lost = 1'b0;
        if (e >= 86) begin
            q = 128'(sig) << (e - 86);
        end else if (86 - e >= 24) begin
            q    = '0;
            lost = (sig != 0);
        end else begin
            q    = 128'(sig) >> (86 - e);
            lost = ((sig & ((24'd1 << (86 - e)) - 24'd1)) != 0);
        end
        ip    = q[127:64];
        half  = q[63];
        rest  = (|q[62:0]) | lost;
        exact = !half && !rest;
        case (m)
            2'b00:   up = half && (rest || ip[0]);
            2'b01:   up = s && !exact;
            2'b10:   up = !s && !exact;
            default: up = 1'b0;
        endcase
        mag = {1'b0, ip} + 65'(up);
        if (mag[64] || (s && mag != 0)) return;
        inv = 1'b0;
        r   = s ? 64'd0 : mag[63:0];
        inx = !exact;
    endtask

    task automatic compare_head();
        logic [63:0] er;
        logic        ev, ex;
        string       rq;
        er = q_res.pop_front();
        ev = q_inv.pop_front();
        ex = q_inx.pop_front();
        rq = q_req.pop_front();
        checks++;
        if (result_o !== er || invalid_o !== ev || inexact_o !== ex) begin
            fails++;
            $display("FAIL %s: got res=%h inv=%b inx=%b, expected res=%h inv=%b inx=%b",
                     rq, result_o, invalid_o, inexact_o, er, ev, ex);
        end
    endtask

    task automatic step(input logic [31:0] f, input logic [1:0] m, input string req);
        logic [63:0] r;
        logic        v, x;
        @(negedge clk);
        if (q_res.size() > 0) compare_head();
        fp_i = f;
        rm_i = m;
        ref_conv(f, m, r, v, x);
        q_res.push_back(r);
        q_inv.push_back(v);
        q_inx.push_back(x);
        q_req.push_back(req);
    endtask

    task automatic flush();
        @(negedge clk);
        while (q_res.size() > 0) compare_head();
    endtask

    task automatic expect_now(input logic [63:0] r, input logic v, input logic x, input string req);
        checks++;
        if (result_o !== r || invalid_o !== v || inexact_o !== x) begin
            fails++;
            $display("FAIL %s: got res=%h inv=%b inx=%b, expected res=%h inv=%b inx=%b",
                     req, result_o, invalid_o, inexact_o, r, v, x);
        end
    endtask

    initial begin
        logic [31:0] lfsr;
        // R11: outputs held at zero in reset even with a live operand
        fp_i = 32'h3F80_0000;
        repeat (3) @(negedge clk);
        expect_now(64'd0, 1'b0, 1'b0, "R11 reset");
        rst_n = 1'b1;

        // R1 exact integers
        step(32'h3F80_0000, 2'b00, "R1 one");
        step(32'h5380_0000, 2'b10, "R1 2^40");
        step(32'h42F6_0000, 2'b01, "R1 123");
        step(32'h42F6_0000, 2'b11, "R1 123 rtz");
        // R2 nearest-even ties
        step(32'h4020_0000, 2'b00, "R2 2.5");
        step(32'h4060_0000, 2'b00, "R2 3.5");
        step(32'h3F00_0000, 2'b00, "R2 0.5");
        step(32'h3FC0_0000, 2'b00, "R2 1.5");
        step(32'h402C_CCCD, 2'b00, "R2 2.7");
        // R3 / R4 / R5 directed
        step(32'h402C_CCCD, 2'b01, "R3 2.7 down");
        step(32'hBECC_CCCD, 2'b01, "R3 -0.4 down");
        step(32'h402C_CCCD, 2'b10, "R4 2.7 up");
        step(32'hBECC_CCCD, 2'b10, "R4 -0.4 up");
        step(32'h402C_CCCD, 2'b11, "R5 2.7 rtz");
        step(32'hBECC_CCCD, 2'b11, "R5 -0.4 rtz");
        // R6 specials
        step(32'h7FC0_0000, 2'b00, "R6 qnan");
        step(32'h7F80_0001, 2'b10, "R6 snan");
        step(32'h7F80_0000, 2'b01, "R6 +inf");
        step(32'hFF80_0000, 2'b11, "R6 -inf");
        // R7 range
        step(32'h5F80_0000, 2'b00, "R7 2^64");
        step(32'h5F7F_FFFF, 2'b10, "R7 max in range");
        step(32'h7F7F_FFFF, 2'b11, "R7 max finite");
        // R8 negatives
        step(32'h8000_0000, 2'b01, "R8 -0");
        step(32'hBF80_0000, 2'b11, "R8 -1");
        step(32'hBECC_CCCD, 2'b00, "R8 -0.4 nearest");
        // R9 subnormals
        step(32'h0000_0001, 2'b00, "R9 sub nearest");
        step(32'h0000_0001, 2'b10, "R9 sub up");
        step(32'h007F_FFFF, 2'b11, "R9 sub rtz");
        step(32'h8000_0001, 2'b01, "R9 neg sub down");
        step(32'h8000_0001, 2'b10, "R9 neg sub up");
        flush();

        // R10 flag behaviour across a pseudo-random sweep, back to back (R11 latency)
        lfsr = 32'hACE1_2345;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step({lfsr[31], 2'b10 ^ lfsr[30:29], lfsr[28:0]}, lfsr[5:4], "R10 sweep");
        end
        flush();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R11 watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule